// File: doc/BRIEF.md
# Alert Status Register and Interrupt Latch

This block keeps the alert-side status word of a seven-channel temperature monitor (one on-die channel, six external ones) and drives the active-low interrupt pin that tells the host something needs attention. Threshold comparison happens elsewhere. At the end of every conversion this block receives one "over limit" flag per channel together with a strobe. For each flagged channel it sets a sticky status bit.

The host clears the status word by reading it. The bus-side alert-response logic can also silence the pin with a one-cycle clear pulse. That pulse leaves the status bits in place, so the host can still read them later. A seven-bit mask word keeps chosen channels off the pin, while their status bits still record events. A fault that is still present sets its bit again at the next conversion, and the pin asserts again at that point.

Top module: `alrt_status_top`

## Requirements
- R1: After the synchronous active-high reset, the status word reads 0 and `alert_n` is 1.
- R2: On a cycle with `conv_done`=1, each channel whose `over_flag` bit is 1 has its status bit set on the next clock edge. Flags presented without `conv_done` have no effect.
- R3: Status bits hold their value until a `stat_rd` strobe. On that strobe, every bit not set in the same cycle clears on the next edge.
- R4: When a set event (`conv_done` with the flag bit at 1) and `stat_rd` fall in the same cycle, the set wins and the bit ends up 1.
- R5: A conversion that sets any status bit whose mask bit is 0 drives `alert_n` low on the next edge. Mask bit 6 belongs to the local channel and bits 5..0 to the remote channels 5..0. A mask bit of 1 means masked.
- R6: A masked channel still sets its status bit, but it does not pull `alert_n` low.
- R7: An `ara_clr` pulse returns `alert_n` to 1 on the next edge and leaves the status word unchanged.
- R8: After `alert_n` has been cleared, a conversion that still flags an unmasked channel drives `alert_n` low again. This holds even when `ara_clr` arrives in that same cycle.
- R9: A `stat_rd` strobe with no unmasked set event in the same cycle returns `alert_n` to 1 on the next edge.
- R10: `alert_n` is low only while the interrupt latch is armed and at least one status bit with mask bit 0 is set. Masking every set bit releases the pin one cycle later, and unmasking again re-asserts it while the latch is still armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle strobe at the end of a conversion |
| over_flag | input | 7 | Per-channel over-limit flags; bit 6 local, 5..0 remote |
| stat_rd | input | 1 | One-cycle strobe: host has read the status word |
| ara_clr | input | 1 | One-cycle clear from the alert-response logic |
| irq_mask | input | 7 | Interrupt mask, 1 = channel kept off the pin |
| status | output | 7 | Registered status word as the host would read it |
| alert_n | output | 1 | Registered interrupt pin, active low |

## Verification
A vector table runs the block through several pattern classes, each isolating one effect.
- A lone conversion on one remote channel, followed by idle cycles with every flag high but no strobe, separates the set event from stray flags.
- An alert-response clear followed by a repeat conversion separates the pin latch from the status word, and shows that a persistent fault re-asserts the pin.
- Read and set in the same cycle, on the same bit and on disjoint bits, shows that set wins bit by bit while the other bits clear.
- Mask toggles while the status is unchanged show that the pin follows the mask, and that a masked event never arms the latch.

// File: rtl/alrt_pkg.sv
package alrt_pkg;
  localparam int CH_COUNT  = 7;
  localparam int LOCAL_BIT = 6;

  // Reduces a status word through its mask: 1 when any unmasked bit is set
  function automatic logic any_open(input logic [CH_COUNT-1:0] bits,
                                    input logic [CH_COUNT-1:0] msk);
    return |(bits & ~msk);
  endfunction
endpackage

// File: rtl/alrt_stat_cell.sv
module alrt_stat_cell (
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic flag,
  input  logic rd_clr,
  output logic set_evt,
  output logic q_nx,
  output logic q
);
  assign set_evt = conv_done & flag;

  always_comb begin
    q_nx = q;
    if (rd_clr)  q_nx = 1'b0;
    if (set_evt) q_nx = 1'b1;   // set has priority over read-clear
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nx;
  end

  // R2, R4
  cell_set_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && flag) |=> q);

  // R3
  cell_rdclr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(conv_done && flag)) |=> !q);

  // R3
  cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && !(conv_done && flag)) |=> $stable(q));
endmodule

// File: rtl/alrt_pin_latch.sv
module alrt_pin_latch #(
  parameter int NCH = alrt_pkg::CH_COUNT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_evt,
  input  logic [NCH-1:0] stat_nx,
  input  logic [NCH-1:0] irq_mask,
  input  logic           stat_rd,
  input  logic           ara_clr,
  output logic           alert_n
);
  logic armed_q, armed_nx, fresh;

  assign fresh = alrt_pkg::any_open(set_evt, irq_mask);

  always_comb begin
    armed_nx = armed_q;
    if (stat_rd || ara_clr) armed_nx = 1'b0;
    if (fresh)              armed_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      alert_n <= 1'b1;
    end else begin
      armed_q <= armed_nx;
      alert_n <= ~(armed_nx & alrt_pkg::any_open(stat_nx, irq_mask));
    end
  end

  // R5, R8
  pin_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (|(set_evt & ~irq_mask)) |=> !alert_n);

  // R7
  ara_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ara_clr && !(|(set_evt & ~irq_mask))) |=> alert_n);

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(|(set_evt & ~irq_mask))) |=> alert_n);
endmodule

// File: rtl/alrt_status_top.sv
module alrt_status_top #(
  parameter int NCH = alrt_pkg::CH_COUNT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           conv_done,
  input  logic [NCH-1:0] over_flag,
  input  logic           stat_rd,
  input  logic           ara_clr,
  input  logic [NCH-1:0] irq_mask,
  output logic [NCH-1:0] status,
  output logic           alert_n
);
  logic [NCH-1:0] set_evt, stat_nx;

  for (genvar c = 0; c < NCH; c++) begin : g_cell
    alrt_stat_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .conv_done(conv_done),
      .flag     (over_flag[c]),
      .rd_clr   (stat_rd),
      .set_evt  (set_evt[c]),
      .q_nx     (stat_nx[c]),
      .q        (status[c])
    );
  end

  alrt_pin_latch #(.NCH(NCH)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_evt),
    .stat_nx (stat_nx),
    .irq_mask(irq_mask),
    .stat_rd (stat_rd),
    .ara_clr (ara_clr),
    .alert_n (alert_n)
  );

  // R10
  pin_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> (status != '0));

  // R7
  ara_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
    (ara_clr && !stat_rd && !conv_done) |=> $stable(status));
endmodule

// File: tb/sim_alrt_status_top.sv
`timescale 1ns/100ps
module sim_alrt_status_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_done = 1'b0, stat_rd = 1'b0, ara_clr = 1'b0;
  logic [6:0] over_flag = '0, irq_mask = '0;
  logic [6:0] status;
  logic alert_n;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  alrt_status_top u0 (.*);

  // {conv, flags[7], rd, ara, mask[7], exp_status[7], exp_alert_n}
  localparam int NV = 16;
  localparam logic [24:0] TBL [NV] = '{
    {1'b1, 7'h01, 1'b0, 1'b0, 7'h00, 7'h01, 1'b0}, // R2 R5
    {1'b0, 7'h7f, 1'b0, 1'b0, 7'h00, 7'h01, 1'b0}, // R2 R3 no strobe
    {1'b0, 7'h00, 1'b0, 1'b1, 7'h00, 7'h01, 1'b1}, // R7
    {1'b1, 7'h01, 1'b0, 1'b0, 7'h00, 7'h01, 1'b0}, // R8
    {1'b0, 7'h00, 1'b1, 1'b0, 7'h00, 7'h00, 1'b1}, // R3 R9
    {1'b1, 7'h40, 1'b0, 1'b0, 7'h40, 7'h40, 1'b1}, // R6 local masked
    {1'b0, 7'h00, 1'b0, 1'b0, 7'h00, 7'h40, 1'b1}, // R10 not armed
    {1'b1, 7'h40, 1'b1, 1'b0, 7'h00, 7'h40, 1'b0}, // R4 set beats read
    {1'b0, 7'h00, 1'b0, 1'b0, 7'h40, 7'h40, 1'b1}, // R10 masked off
    {1'b0, 7'h00, 1'b0, 1'b0, 7'h00, 7'h40, 1'b0}, // R10 unmasked again
    {1'b1, 7'h22, 1'b1, 1'b0, 7'h00, 7'h22, 1'b0}, // R4 R3 disjoint bits
    {1'b0, 7'h00, 1'b1, 1'b1, 7'h00, 7'h00, 1'b1}, // R3 R9
    {1'b1, 7'h21, 1'b0, 1'b0, 7'h21, 7'h21, 1'b1}, // R6
    {1'b1, 7'h21, 1'b0, 1'b0, 7'h01, 7'h21, 1'b0}, // R5 remote 5 open
    {1'b0, 7'h00, 1'b1, 1'b0, 7'h00, 7'h00, 1'b1}, // R9
    {1'b1, 7'h01, 1'b0, 1'b1, 7'h00, 7'h01, 1'b0}  // R8 set beats ara
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2/R5";  1: return "R2/R3";  2: return "R7";
      3: return "R8";     4: return "R3/R9";  5: return "R6";
      6: return "R10";    7: return "R4";     8: return "R10";
      9: return "R10";   10: return "R4/R3"; 11: return "R3/R9";
      12: return "R6";   13: return "R5";    14: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [6:0] es, logic ea);
    checks++;
    if (status !== es || alert_n !== ea) begin
      errs++;
      $display("FAIL %s: status=%h alert_n=%b expected status=%h alert_n=%b",
               req, status, alert_n, es, ea);
    end
  endtask

  task automatic drive(logic cv, logic [6:0] fl, logic rd, logic ar, logic [6:0] mk);
    @(negedge clk);
    conv_done = cv; over_flag = fl; stat_rd = rd; ara_clr = ar; irq_mask = mk;
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 7'h00, 1'b1);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = TBL[i];
      drive(v[24], v[23:17], v[16], v[15], v[14:8]);
      check(tag_of(i), v[7:1], v[0]);
    end
    // R1: reset mid-run with status set and pin low
    @(negedge clk) rst = 1'b1; conv_done = 1'b0;
    @(posedge clk); #1 check("R1 mid-run reset", 7'h00, 1'b1);
    @(negedge clk) rst = 1'b0;
    // R2: flags alone after reset change nothing
    drive(1'b0, 7'h7f, 1'b0, 1'b0, 7'h00);
    check("R2 flags without strobe", 7'h00, 1'b1);
    // R7: status stays readable after ara clear
    drive(1'b1, 7'h7f, 1'b0, 1'b0, 7'h00);
    check("R5 all channels", 7'h7f, 1'b0);
    drive(1'b0, 7'h00, 1'b0, 1'b1, 7'h00);
    check("R7 status retained", 7'h7f, 1'b1);
    drive(1'b0, 7'h00, 1'b0, 1'b0, 7'h00);
    check("R7 pin stays released", 7'h7f, 1'b1);
    drive(1'b0, 7'h00, 1'b1, 1'b0, 7'h00);
    check("R3 read clears", 7'h00, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule